// File: doc/BRIEF.md
# Register Busy Scoreboard with Queue-Mapped Register

This block records which architectural registers have a result still in flight, so that an in-order dispatcher can hold back any instruction that would read a stale value, overwrite a value still being read, or reorder two writes to the same register. The dispatcher presents the two source register numbers and the destination register number of its next instruction. It receives a single-cycle "may dispatch" answer. That answer is computed combinationally from the current busy vector.

A busy bit is raised by the dispatcher's set port when an instruction issues. For an ordinary register, the bit drops when the register file reports the write-back of that register. One register number is not backed by a storage cell but by a FIFO queue. Its bit ignores register write-back. It drops only when the dispatcher receives the completion status saying the result has entered the queue, which forces producers of the queue to finish one at a time. Register 0 is hard-wired to zero. It has no busy bit and never stalls anything.

Top module: `reg_scoreboard`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every busy bit. The reset wins over a set in the same cycle. After reset, `may_dispatch` is 1 for any register numbers.
- R2: `set_valid` with `set_idx` = k (k not 0) makes `busy[k]` 1 from the next rising edge.
- R3: `wb_valid` with `wb_idx` = k, where k is neither 0 nor the queue register (register 1), makes `busy[k]` 0 from the next rising edge.
- R4: A write-back naming the queue register (`wb_idx` = 1) has no effect on `busy[1]`.
- R5: `qdone_valid` high makes `busy[1]` 0 from the next rising edge.
- R6: Register 0 is never tracked. A set naming register 0 changes no bit. A source or destination of 0 never pulls `may_dispatch` low.
- R7: `may_dispatch` is 0 while `src_a` or `src_b` names a busy register.
- R8: `may_dispatch` is 0 while `dst` names a busy register.
- R9: `may_dispatch` follows changes of `src_a`, `src_b` and `dst` in the same cycle, with no clock edge needed.
- R10: A set and a clear of the same register in the same cycle leave that register busy. A set and a clear of different registers in one cycle both take effect.
- R11: Bits that no set, write-back or completion names keep their value across a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| set_valid | input | 1 | Dispatch marks a destination busy |
| set_idx | input | 5 | Register number to mark busy |
| wb_valid | input | 1 | Register-file write-back arrived |
| wb_idx | input | 5 | Register number written back |
| qdone_valid | input | 1 | Completion status: result entered the queue register |
| src_a | input | 5 | First source register of the candidate instruction |
| src_b | input | 5 | Second source register of the candidate instruction |
| dst | input | 5 | Destination register of the candidate instruction |
| may_dispatch | output | 1 | 1 when the candidate has no register hazard |
| busy | output | 31 | Busy bits for registers 31 down to 1 (declared [31:1]) |

## Verification
The bench targets the cycle where a dispatch and a write-back name the same register. A design that lets the clear win would release a register with a write still pending, and would then admit a second writer out of order. It sends a write-back to the queue register with no completion. A design that treats that register like the others would free the queue producer early. It also sends register 0 as a set target and as every operand. A design that tracks it would either grow a bit that never clears or stall instructions that have no real dependency. Further checks change the sources with the clock held still, to catch a decision that was wrongly registered, and assert reset together with a set, to catch a set that outranks reset.

// File: rtl/regsb_pkg.sv
package regsb_pkg;

   // Default geometry of the tracked register file.
   localparam int unsigned REGSB_DEF_REGS = 32;
   // Register number that is backed by a FIFO queue (0 disables the mapping).
   localparam int unsigned REGSB_DEF_QREG = 1;

   function automatic bit regsb_is_pow2(input int unsigned val);
      return (val != 0) && ((val & (val - 1)) == 0);
   endfunction

endpackage

// File: rtl/regsb_decode.sv
module regsb_decode #(
   parameter int unsigned NUM_REGS = 32,
   localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
   input  logic                en,
   input  logic [IDX_W-1:0]    idx,
   output logic [NUM_REGS-1:1] hot
);

   // Register 0 has no output bit, so a request naming it decodes to nothing.
   for (genvar g = 1; g < NUM_REGS; g++) begin : g_line
      assign hot[g] = en && (idx == IDX_W'(g));
   end

endmodule

// File: rtl/regsb_state.sv
module regsb_state #(
   parameter int unsigned NUM_REGS = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_REGS-1:1] set_hot,
   input  logic [NUM_REGS-1:1] clr_hot,
   output logic [NUM_REGS-1:1] busy_q
);

   logic [NUM_REGS-1:1] busy_d;

   // The clear is applied first, then the set, so a dispatch in the same
   // cycle as the retirement of an older writer keeps the bit raised.
   always_comb begin
      busy_d = (busy_q & ~clr_hot) | set_hot;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= '0;
      end else begin
         busy_q <= busy_d;
      end
   end

endmodule

// File: rtl/regsb_hazard.sv
module regsb_hazard #(
   parameter int unsigned NUM_REGS = 32,
   localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:1] busy_q,
   input  logic [IDX_W-1:0]    rd_a,
   input  logic [IDX_W-1:0]    rd_b,
   input  logic [IDX_W-1:0]    wr,
   output logic                clear_to_go
);

   // Position 0 is tied low so register 0 can never report a hazard.
   logic [NUM_REGS-1:0] padded;
   logic                raw_hit;
   logic                waw_hit;

   assign padded = {busy_q, 1'b0};

   always_comb begin
      raw_hit     = padded[rd_a] | padded[rd_b];
      waw_hit     = padded[wr];
      clear_to_go = !(raw_hit || waw_hit);
   end

endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
   import regsb_pkg::*;
#(
   parameter int unsigned NUM_REGS  = REGSB_DEF_REGS,
   parameter int unsigned QUEUE_REG = REGSB_DEF_QREG,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                set_valid,
   input  logic [IDX_W-1:0]    set_idx,
   input  logic                wb_valid,
   input  logic [IDX_W-1:0]    wb_idx,
   input  logic                qdone_valid,
   input  logic [IDX_W-1:0]    src_a,
   input  logic [IDX_W-1:0]    src_b,
   input  logic [IDX_W-1:0]    dst,
   output logic                may_dispatch,
   output logic [NUM_REGS-1:1] busy
);

   // Elaboration-time parameter checks.
   if (!regsb_is_pow2(NUM_REGS) || NUM_REGS < 4) begin : g_bad_regs
      $error("reg_scoreboard: NUM_REGS must be a power of two, at least 4");
   end
   if (QUEUE_REG >= NUM_REGS) begin : g_bad_qreg
      $error("reg_scoreboard: QUEUE_REG must name an existing register");
   end

   logic [NUM_REGS-1:1] set_hot;
   logic [NUM_REGS-1:1] wb_hot;
   logic [NUM_REGS-1:1] clr_hot;

   regsb_decode #(.NUM_REGS(NUM_REGS)) u_set_dec (
      .en  (set_valid),
      .idx (set_idx),
      .hot (set_hot)
   );

   regsb_decode #(.NUM_REGS(NUM_REGS)) u_wb_dec (
      .en  (wb_valid),
      .idx (wb_idx),
      .hot (wb_hot)
   );

   // Clear routing: an ordinary register clears on write-back. The queue
   // register clears only on the completion status, never on write-back.
   for (genvar g = 1; g < NUM_REGS; g++) begin : g_clr
      if (g == QUEUE_REG) begin : g_queue
         assign clr_hot[g] = qdone_valid;
      end else begin : g_plain
         assign clr_hot[g] = wb_hot[g];
      end
   end

   if (QUEUE_REG == 0) begin : g_no_queue
      logic unused_qdone;
      assign unused_qdone = qdone_valid;
   end

   regsb_state #(.NUM_REGS(NUM_REGS)) u_state (
      .clk     (clk),
      .rst     (rst),
      .set_hot (set_hot),
      .clr_hot (clr_hot),
      .busy_q  (busy)
   );

   regsb_hazard #(.NUM_REGS(NUM_REGS)) u_haz (
      .busy_q      (busy),
      .rd_a        (src_a),
      .rd_b        (src_b),
      .wr          (dst),
      .clear_to_go (may_dispatch)
   );

endmodule

// File: rtl/reg_scoreboard_chk.sv
module reg_scoreboard_chk #(
   parameter int unsigned NUM_REGS  = 32,
   parameter int unsigned QUEUE_REG = 1,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input logic                clk,
   input logic                rst,
   input logic                set_valid,
   input logic [IDX_W-1:0]    set_idx,
   input logic                wb_valid,
   input logic [IDX_W-1:0]    wb_idx,
   input logic                qdone_valid,
   input logic [IDX_W-1:0]    src_a,
   input logic [IDX_W-1:0]    src_b,
   input logic [IDX_W-1:0]    dst,
   input logic                may_dispatch,
   input logic [NUM_REGS-1:1] busy
);

   logic [NUM_REGS-1:0] view;
   logic                q_set;

   assign view  = {busy, 1'b0};
   assign q_set = set_valid && (set_idx == IDX_W'(QUEUE_REG));

   // R1: the first cycle after reset shows an empty vector
   a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (busy == '0));

   // R2 and R10: a set reaches its bit even when a clear collides with it
   a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
      (set_valid && set_idx != '0) |=> view[$past(set_idx)]);

   // R3: write-back of a plain register frees it unless re-set
   a_r3_wb_frees: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && wb_idx != '0 && wb_idx != IDX_W'(QUEUE_REG) &&
       !(set_valid && set_idx == wb_idx)) |=> !view[$past(wb_idx)]);

   // R4: write-back naming the queue register leaves its bit alone
   a_r4_queue_wb_ignored: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && wb_idx == IDX_W'(QUEUE_REG) && !qdone_valid && !q_set)
      |=> (view[QUEUE_REG] == $past(view[QUEUE_REG])));

   // R5: completion status frees the queue register unless re-set
   a_r5_qdone_frees: assert property (@(posedge clk) disable iff (rst)
      (qdone_valid && !q_set) |=> !view[QUEUE_REG]);

   // R6: an instruction touching only register 0 is never held
   a_r6_zero_free: assert property (@(posedge clk) disable iff (rst)
      (src_a == '0 && src_b == '0 && dst == '0) |-> may_dispatch);

   // R7: no dispatch while a source is busy
   a_r7_raw_block: assert property (@(posedge clk) disable iff (rst)
      may_dispatch |-> (!view[src_a] && !view[src_b]));

   // R8: no dispatch while the destination is busy
   a_r8_waw_block: assert property (@(posedge clk) disable iff (rst)
      may_dispatch |-> !view[dst]);

   // R11: with no request at all the vector holds
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!set_valid && !wb_valid && !qdone_valid) |=> $stable(busy));

endmodule

bind reg_scoreboard reg_scoreboard_chk #(
   .NUM_REGS  (NUM_REGS),
   .QUEUE_REG (QUEUE_REG)
) u_chk (.*);

// File: tb/reg_scoreboard_bench.sv
module reg_scoreboard_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        set_valid = 1'b0;
   logic [4:0]  set_idx = '0;
   logic        wb_valid = 1'b0;
   logic [4:0]  wb_idx = '0;
   logic        qdone_valid = 1'b0;
   logic [4:0]  src_a = '0;
   logic [4:0]  src_b = '0;
   logic [4:0]  dst = '0;
   logic        may_dispatch;
   logic [31:1] busy;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   reg_scoreboard u_reg_scoreboard (
      .clk          (clk),
      .rst          (rst),
      .set_valid    (set_valid),
      .set_idx      (set_idx),
      .wb_valid     (wb_valid),
      .wb_idx       (wb_idx),
      .qdone_valid  (qdone_valid),
      .src_a        (src_a),
      .src_b        (src_b),
      .dst          (dst),
      .may_dispatch (may_dispatch),
      .busy         (busy)
   );

   // Vector: set_v, set_i, wb_v, wb_i, qdone, src_a, src_b, dst,
   //         expected {busy,0} after the edge, expected may_dispatch.
   localparam int NV = 12;
   localparam logic [60:0] TBL [NV] = '{
      {1'b1,5'd5, 1'b0,5'd0, 1'b0, 5'd5, 5'd0, 5'd0, 32'h0000_0020, 1'b0},  // R2 R7
      {1'b1,5'd1, 1'b0,5'd0, 1'b0, 5'd0, 5'd0, 5'd7, 32'h0000_0022, 1'b1},  // R2 R11
      {1'b1,5'd9, 1'b1,5'd1, 1'b0, 5'd1, 5'd0, 5'd0, 32'h0000_0222, 1'b0},  // R4
      {1'b0,5'd0, 1'b0,5'd0, 1'b1, 5'd1, 5'd0, 5'd0, 32'h0000_0220, 1'b1},  // R5
      {1'b1,5'd3, 1'b1,5'd5, 1'b0, 5'd0, 5'd5, 5'd0, 32'h0000_0208, 1'b1},  // R3 R10
      {1'b1,5'd0, 1'b1,5'd0, 1'b0, 5'd0, 5'd0, 5'd0, 32'h0000_0208, 1'b1},  // R6
      {1'b1,5'd3, 1'b1,5'd3, 1'b0, 5'd0, 5'd0, 5'd3, 32'h0000_0208, 1'b0},  // R10 R8
      {1'b1,5'd31,1'b1,5'd9, 1'b0, 5'd0, 5'd31,5'd0, 32'h8000_0008, 1'b0},  // R3 R7
      {1'b0,5'd0, 1'b1,5'd31,1'b1, 5'd2, 5'd4, 5'd6, 32'h0000_0008, 1'b1},  // R3 R5
      {1'b1,5'd1, 1'b0,5'd0, 1'b1, 5'd0, 5'd0, 5'd1, 32'h0000_000A, 1'b0},  // R10 R8
      {1'b0,5'd0, 1'b1,5'd3, 1'b0, 5'd3, 5'd0, 5'd0, 32'h0000_0002, 1'b1},  // R3
      {1'b0,5'd0, 1'b0,5'd0, 1'b1, 5'd1, 5'd1, 5'd1, 32'h0000_0000, 1'b1}   // R5
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #100000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      src_a = 5'd1; src_b = 5'd2; dst = 5'd3;
      #1;
      check("R1 busy after reset", {busy, 1'b0}, 32'h0);
      check("R1 may_dispatch after reset", {31'b0, may_dispatch}, 32'h1);

      for (int i = 0; i < NV; i++) begin
         {set_valid, set_idx, wb_valid, wb_idx, qdone_valid, src_a, src_b, dst} = TBL[i][60:33];
         @(negedge clk);
         check($sformatf("R2-table vec %0d busy", i), {busy, 1'b0}, TBL[i][32:1]);
         check($sformatf("R7/R8 table vec %0d may_dispatch", i), {31'b0, may_dispatch},
               {31'b0, TBL[i][0]});
      end

      // R9: decision follows the operands with no clock edge
      {set_valid, wb_valid, qdone_valid} = 3'b100;
      set_idx = 5'd2; src_a = '0; src_b = '0; dst = '0;
      @(negedge clk);
      set_valid = 1'b0;
      check("R9 busy holds reg2", {busy, 1'b0}, 32'h4);
      src_a = 5'd2;
      #1;
      check("R9 src_a busy same cycle", {31'b0, may_dispatch}, 32'h0);
      src_a = 5'd4;
      #1;
      check("R9 src_a free same cycle", {31'b0, may_dispatch}, 32'h1);
      dst = 5'd2;
      #1;
      check("R9 R8 dst busy same cycle", {31'b0, may_dispatch}, 32'h0);
      dst = 5'd0;

      // R11: idle edge keeps the vector
      @(negedge clk);
      check("R11 idle hold", {busy, 1'b0}, 32'h4);

      // R1: reset beats a same-cycle set
      rst = 1'b1; set_valid = 1'b1; set_idx = 5'd7;
      @(negedge clk);
      rst = 1'b0; set_valid = 1'b0;
      #1;
      check("R1 reset over set", {busy, 1'b0}, 32'h0);

      finish_run();
   end

endmodule